// File: doc/BRIEF.md
# Radix-16 Residual Adder with Reduced Carry Storage

This block holds and updates the partial remainder of a radix-16 digit-recurrence divider. Each step multiplies the stored remainder by sixteen and adds two divisor multiples. One multiple belongs to the upper quotient sub-digit and one to the lower. A multiple that is to be subtracted arrives already inverted, and its negation carry-in arrives as a separate bit. The remainder stays redundant throughout: a full-width sum vector plus a carry vector. No carry-propagate addition runs across the whole word.

The low-order region is split into 4-bit radix-16 digits. Each digit is built from two 4-bit ripple adders in series. The first adds the shifted sum, the upper multiple and the stored carry entering the digit. The second adds the lower multiple and the first-level carry coming up from the digit below. Only the second-level carry out of each digit is stored, so the low region needs one carry flop per digit rather than one per bit. The upper region keeps a bitwise carry-save form in two 3:2 levels. Both carries leaving the top low digit enter the lowest upper bit, so no weight is lost at the seam.

A load strobe writes the dividend into the sum vector and clears every carry. A step strobe applies one recurrence step. When neither strobe is high, the state holds.

Top module: `r16csa_top`

## Requirements
- R1: After a synchronous reset, `sumOut`, `carryUpOut` and `carryDigOut` are all zero.
- R2: When `loadEn` is high, the next cycle shows `sumOut` equal to `initVal`, with `carryUpOut` and `carryDigOut` both zero.
- R3: When `loadEn` and `stepEn` are high in the same cycle, the load takes effect and the step is ignored.
- R4: When neither `loadEn` nor `stepEn` is high, all three outputs keep their values.
- R5: The represented value V is `sumOut` plus `carryUpOut`·2^LOW plus the sum over k = 1..LOW_DIGITS-1 of `carryDigOut[k-1]`·2^(4k), taken modulo 2^W, where LOW = 4·LOW_DIGITS and W = LOW + HIGH_BITS. After a step, V equals 16·V_prev + `multHi` + `cinHi` + `multLo` + `cinLo`, modulo 2^W.
- R6: After a step, `sumOut[3:0]` equals (`multHi[3:0]` + `multLo[3:0]` + `cinHi` + `cinLo`) mod 16. The two negation carry-ins enter at the least-significant digit.
- R7: A carry produced by the top digit of the low region is carried into the upper region without loss. For example, W = 12 with LOW = 8, a load of 0x00F followed by a step with `multHi` = 0x0F0 and all other addends zero gives V = 0x1E0.
- R8: The carry state is LOW_DIGITS-1 digit-boundary bits plus HIGH_BITS upper bits. The R5 relation holds over several consecutive steps starting from any loaded value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| loadEn | input | 1 | Write `initVal` into the sum, clear the carries |
| stepEn | input | 1 | Apply one recurrence step |
| initVal | input | W | Initial remainder |
| multHi | input | W | Upper sub-digit multiple, two's complement bits |
| cinHi | input | 1 | Negation carry-in for `multHi` |
| multLo | input | W | Lower sub-digit multiple, two's complement bits |
| cinLo | input | 1 | Negation carry-in for `multLo` |
| sumOut | output | W | Stored sum vector |
| carryUpOut | output | HIGH_BITS | Bitwise carries of the upper region, bit 0 at weight 2^LOW |
| carryDigOut | output | LOW_DIGITS-1 | One carry per digit boundary, bit k-1 at weight 2^(4k) |

## Verification
The bench builds the block with LOW_DIGITS = 2 and HIGH_BITS = 4. That makes a 12-bit word with one stored digit-boundary carry and a 4-bit upper region. With a word this small, the bench can run a dense sweep of dividends and multiple pairs, including all-ones, zero and inverted patterns, through chains of three steps. This exercises every digit-seam carry, the hand-off into the upper region and wraparound at the top. Each result is checked against the modular sum computed from the previous outputs.

// File: rtl/r16csa_pkg.sv
package r16csa_pkg;
  localparam int DIGIT_W = 4;

  typedef struct packed {
    logic capture;
    logic selInit;
  } ctrlStrobes_t;
endpackage

// File: rtl/r16csa_digit.sv
module r16csa_digit #(
  parameter int DW = 4
) (
  input  logic [DW-1:0] aIn,
  input  logic [DW-1:0] bIn,
  input  logic          cIn,
  output logic [DW-1:0] sOut,
  output logic          cOut
);
  logic rip;

  always_comb begin
    rip = cIn;
    for (int i = 0; i < DW; i++) begin
      sOut[i] = aIn[i] ^ bIn[i] ^ rip;
      rip     = (aIn[i] & bIn[i]) | (rip & (aIn[i] ^ bIn[i]));
    end
    cOut = rip;
  end
endmodule

// File: rtl/r16csa_ctrl.sv
module r16csa_ctrl
  import r16csa_pkg::*;
(
  input  logic         loadEn,
  input  logic         stepEn,
  output ctrlStrobes_t strobes
);
  always_comb begin
    strobes.selInit = loadEn;
    strobes.capture = loadEn | stepEn;
  end
endmodule

// File: rtl/r16csa_dp.sv
module r16csa_dp
  import r16csa_pkg::*;
#(
  parameter int LOW_DIGITS = 11,
  parameter int HIGH_BITS  = 13
) (
  input  logic                  clk,
  input  logic                  rst,
  input  ctrlStrobes_t          strobes,
  input  logic [LOW_DIGITS*DIGIT_W+HIGH_BITS-1:0] initVal,
  input  logic [LOW_DIGITS*DIGIT_W+HIGH_BITS-1:0] multHi,
  input  logic                  cinHi,
  input  logic [LOW_DIGITS*DIGIT_W+HIGH_BITS-1:0] multLo,
  input  logic                  cinLo,
  output logic [LOW_DIGITS*DIGIT_W+HIGH_BITS-1:0] sumQ,
  output logic [HIGH_BITS-1:0]  carryUpQ,
  output logic [LOW_DIGITS-2:0] carryDigQ
);
  localparam int LOW = LOW_DIGITS * DIGIT_W;
  localparam int W   = LOW + HIGH_BITS;

  logic [W-1:0]          shSum;
  logic [LOW_DIGITS-1:0] cin1, cin2, c1, c2;
  logic [LOW-1:0]        lvl1Sum, lvl2Sum;
  logic [HIGH_BITS-1:0]  upShift, hiS1, hiK1, hiK1Sh, hiS2, hiK2, newUp;

  assign shSum = {sumQ[W-DIGIT_W-1:0], {DIGIT_W{1'b0}}};

  // Low region: two ripple levels per digit, one stored carry per digit
  for (genvar k = 0; k < LOW_DIGITS; k++) begin : g_digit
    if (k == 0) begin : g_first
      assign cin1[k] = cinHi;
      assign cin2[k] = cinLo;
    end else if (k == 1) begin : g_second
      assign cin1[k] = 1'b0;
      assign cin2[k] = c1[k-1];
    end else begin : g_rest
      assign cin1[k] = carryDigQ[k-2];
      assign cin2[k] = c1[k-1];
    end

    r16csa_digit #(.DW(DIGIT_W)) lvl1_i (
      .aIn (shSum[k*DIGIT_W +: DIGIT_W]),
      .bIn (multHi[k*DIGIT_W +: DIGIT_W]),
      .cIn (cin1[k]),
      .sOut(lvl1Sum[k*DIGIT_W +: DIGIT_W]),
      .cOut(c1[k])
    );
    r16csa_digit #(.DW(DIGIT_W)) lvl2_i (
      .aIn (lvl1Sum[k*DIGIT_W +: DIGIT_W]),
      .bIn (multLo[k*DIGIT_W +: DIGIT_W]),
      .cIn (cin2[k]),
      .sOut(lvl2Sum[k*DIGIT_W +: DIGIT_W]),
      .cOut(c2[k])
    );
  end

  // Upper region: bitwise carry-save, fed at bit 0 by the top digit's carries
  always_comb begin
    upShift    = carryUpQ << DIGIT_W;
    upShift[0] = carryDigQ[LOW_DIGITS-2];
    hiS1   = shSum[W-1:LOW] ^ upShift ^ multHi[W-1:LOW];
    hiK1   = (shSum[W-1:LOW] & upShift) | (shSum[W-1:LOW] & multHi[W-1:LOW])
           | (upShift & multHi[W-1:LOW]);
    hiK1Sh = {hiK1[HIGH_BITS-2:0], c1[LOW_DIGITS-1]};
    hiS2   = hiS1 ^ hiK1Sh ^ multLo[W-1:LOW];
    hiK2   = (hiS1 & hiK1Sh) | (hiS1 & multLo[W-1:LOW]) | (hiK1Sh & multLo[W-1:LOW]);
    newUp  = {hiK2[HIGH_BITS-2:0], c2[LOW_DIGITS-1]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sumQ      <= '0;
      carryUpQ  <= '0;
      carryDigQ <= '0;
    end else if (strobes.capture) begin
      if (strobes.selInit) begin
        sumQ      <= initVal;
        carryUpQ  <= '0;
        carryDigQ <= '0;
      end else begin
        sumQ      <= {hiS2, lvl2Sum};
        carryUpQ  <= newUp;
        carryDigQ <= c2[LOW_DIGITS-2:0];
      end
    end
  end
endmodule

// File: rtl/r16csa_top.sv
module r16csa_top
  import r16csa_pkg::*;
#(
  parameter int LOW_DIGITS = 11,
  parameter int HIGH_BITS  = 13
) (
  input  logic clk,
  input  logic rst,
  input  logic loadEn,
  input  logic stepEn,
  input  logic [LOW_DIGITS*4+HIGH_BITS-1:0] initVal,
  input  logic [LOW_DIGITS*4+HIGH_BITS-1:0] multHi,
  input  logic cinHi,
  input  logic [LOW_DIGITS*4+HIGH_BITS-1:0] multLo,
  input  logic cinLo,
  output logic [LOW_DIGITS*4+HIGH_BITS-1:0] sumOut,
  output logic [HIGH_BITS-1:0] carryUpOut,
  output logic [LOW_DIGITS-2:0] carryDigOut
);
  ctrlStrobes_t strobes;

  r16csa_ctrl ctrl_i (
    .loadEn (loadEn),
    .stepEn (stepEn),
    .strobes(strobes)
  );

  r16csa_dp #(.LOW_DIGITS(LOW_DIGITS), .HIGH_BITS(HIGH_BITS)) dp_i (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .initVal  (initVal),
    .multHi   (multHi),
    .cinHi    (cinHi),
    .multLo   (multLo),
    .cinLo    (cinLo),
    .sumQ     (sumOut),
    .carryUpQ (carryUpOut),
    .carryDigQ(carryDigOut)
  );
endmodule

// File: rtl/r16csa_chk.sv
module r16csa_chk #(
  parameter int LOW_DIGITS = 11,
  parameter int HIGH_BITS  = 13
) (
  input logic clk,
  input logic rst,
  input logic loadEn,
  input logic stepEn,
  input logic [LOW_DIGITS*4+HIGH_BITS-1:0] initVal,
  input logic [LOW_DIGITS*4+HIGH_BITS-1:0] multHi,
  input logic cinHi,
  input logic [LOW_DIGITS*4+HIGH_BITS-1:0] multLo,
  input logic cinLo,
  input logic [LOW_DIGITS*4+HIGH_BITS-1:0] sumOut,
  input logic [HIGH_BITS-1:0] carryUpOut,
  input logic [LOW_DIGITS-2:0] carryDigOut
);
  localparam int LOW = LOW_DIGITS * 4;
  localparam int W   = LOW + HIGH_BITS;

  logic [W-1:0] totalNow, expNext;
  logic [3:0]   lowExp;

  always_comb begin
    totalNow = sumOut + (W'(carryUpOut) << LOW);
    for (int k = 1; k < LOW_DIGITS; k++)
      totalNow = totalNow + (W'(carryDigOut[k-1]) << (4 * k));
    expNext = (totalNow << 4) + multHi + W'(cinHi) + multLo + W'(cinLo);
    lowExp  = multHi[3:0] + multLo[3:0] + 4'(cinHi) + 4'(cinLo);
  end

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (sumOut == '0 && carryUpOut == '0 && carryDigOut == '0));

  assert_load_init_R2: assert property (@(posedge clk) disable iff (rst)
    loadEn |=> (sumOut == $past(initVal) && carryUpOut == '0 && carryDigOut == '0));

  assert_load_wins_R3: assert property (@(posedge clk) disable iff (rst)
    (loadEn && stepEn) |=> (sumOut == $past(initVal)));

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!loadEn && !stepEn) |=> ($stable(sumOut) && $stable(carryUpOut) && $stable(carryDigOut)));

  assert_step_value_R5: assert property (@(posedge clk) disable iff (rst)
    (stepEn && !loadEn) |=> (totalNow == $past(expNext)));

  assert_low_digit_R6: assert property (@(posedge clk) disable iff (rst)
    (stepEn && !loadEn) |=> (sumOut[3:0] == $past(lowExp)));
endmodule

bind r16csa_top r16csa_chk #(.LOW_DIGITS(LOW_DIGITS), .HIGH_BITS(HIGH_BITS)) chk_i (.*);

// File: tb/r16csa_tb.sv
module r16csa_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LD   = 2;
  localparam int HB   = 4;
  localparam int LOWB = LD * 4;
  localparam int W    = LOWB + HB;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic loadEn = 1'b0, stepEn = 1'b0, cinHi = 1'b0, cinLo = 1'b0;
  logic [W-1:0] initVal = '0, multHi = '0, multLo = '0;
  logic [W-1:0] sumOut;
  logic [HB-1:0] carryUpOut;
  logic [LD-2:0] carryDigOut;

  int checks = 0;
  int fails  = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  r16csa_top #(.LOW_DIGITS(LD), .HIGH_BITS(HB)) dut_i (
    .clk(clk), .rst(rst), .loadEn(loadEn), .stepEn(stepEn),
    .initVal(initVal), .multHi(multHi), .cinHi(cinHi),
    .multLo(multLo), .cinLo(cinLo),
    .sumOut(sumOut), .carryUpOut(carryUpOut), .carryDigOut(carryDigOut)
  );

  function automatic logic [W-1:0] curVal();
    logic [W-1:0] v;
    v = sumOut + (W'(carryUpOut) << LOWB);
    for (int k = 1; k < LD; k++) v = v + (W'(carryDigOut[k-1]) << (4 * k));
    return v;
  endfunction

  function automatic logic [W-1:0] nextRand();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return W'(lfsr);
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cycle(input logic ld, input logic st, input logic [W-1:0] iv,
                       input logic [W-1:0] mh, input logic ch,
                       input logic [W-1:0] ml, input logic cl);
    @(negedge clk);
    loadEn = ld; stepEn = st; initVal = iv;
    multHi = mh; cinHi = ch; multLo = ml; cinLo = cl;
    @(posedge clk);
    #1;
    loadEn = 1'b0; stepEn = 1'b0;
  endtask

  task automatic doStep(input logic [W-1:0] mh, input logic ch,
                        input logic [W-1:0] ml, input logic cl, input string req);
    logic [W-1:0] prev, exp;
    logic [3:0] lowExp;
    prev   = curVal();
    exp    = (prev << 4) + mh + W'(ch) + ml + W'(cl);
    lowExp = mh[3:0] + ml[3:0] + 4'(ch) + 4'(cl);
    cycle(1'b0, 1'b1, nextRand(), mh, ch, ml, cl);
    check(req, curVal(), exp);
    check("R6", W'(sumOut[3:0]), W'(lowExp));
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R1: reset state
    check("R1 sum", sumOut, '0);
    check("R1 carries", W'({carryUpOut, carryDigOut}), '0);

    // R2: load
    cycle(1'b1, 1'b0, 12'hA5C, '0, 1'b0, '0, 1'b0);
    check("R2 sum", sumOut, 12'hA5C);
    check("R2 carries", W'({carryUpOut, carryDigOut}), '0);

    // R4: hold with busy inputs
    doStep(12'hFFF, 1'b1, 12'h0F7, 1'b0, "R5");
    begin
      logic [W-1:0] s0; logic [HB-1:0] u0; logic [LD-2:0] d0;
      s0 = sumOut; u0 = carryUpOut; d0 = carryDigOut;
      cycle(1'b0, 1'b0, 12'h123, 12'h777, 1'b1, 12'h999, 1'b1);
      check("R4 sum", sumOut, s0);
      check("R4 carries", W'({carryUpOut, carryDigOut}), W'({u0, d0}));
    end

    // R3: load beats step
    cycle(1'b1, 1'b1, 12'h3C3, 12'hFFF, 1'b1, 12'hFFF, 1'b1);
    check("R3 sum", sumOut, 12'h3C3);
    check("R3 carries", W'({carryUpOut, carryDigOut}), '0);

    // R7: top low digit carry crosses into upper region
    cycle(1'b1, 1'b0, 12'h00F, '0, 1'b0, '0, 1'b0);
    doStep(12'h0F0, 1'b0, 12'h000, 1'b0, "R7");
    check("R7 exact", curVal(), 12'h1E0);

    // R8 / R5: dense sweep, corner patterns and chained steps
    for (int i = 0; i < 2000; i++) begin
      logic [W-1:0] x, mh, ml;
      x  = nextRand();
      mh = (i % 7 == 0) ? '1 : ((i % 11 == 0) ? '0 : nextRand());
      ml = (i % 5 == 0) ? ~mh : nextRand();
      cycle(1'b1, 1'b0, x, '0, 1'b0, '0, 1'b0);
      check("R2 sweep", sumOut, x);
      for (int s = 0; s < 3; s++) begin
        doStep(mh, logic'(i[0]), ml, logic'(i[1]), "R8");
        mh = nextRand();
        ml = (s == 1) ? '1 : nextRand();
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule